// File: doc/BRIEF.md
# Rotating Word Seven-Segment Display Driver

This block shows a three-letter word on a row of active-low seven-segment digits and rotates it according to a select input. The word arrives as three 2-bit character codes. Each code names one symbol from a four-entry alphabet: the letters d, E and 1, plus a blank. Every digit has its own selection network, which picks the code that digit shows at the current rotation position. A decoder then turns that code into segment drive levels.

A parameter chooses between two builds. The three-digit build takes a 2-bit select and turns the word circularly across three digits. The six-digit build takes a 3-bit select and moves the word right-to-left across six digits, with blanks in the three digits the word does not cover. The block has no storage: the outputs follow the inputs directly. Debouncing, timed scrolling and pin mapping are left to the surrounding logic.

Top module: `rot_word_display`

## Requirements
- R1: The code values map to glyphs as follows: code 00 is d, 01 is E and 10 is 1. Within a digit, segment index 0..6 means a, b, c, d, e, f, g (a is the top segment, the indices run clockwise, g is the middle bar). A segment is lit when driven 0. The drive patterns over indices 0..6 are d = 1000010, E = 0110000 and 1 = 1001111.
- R2: Code 11 drives all seven segments of a digit to 1 (blank).
- R3: The word is code_i[5:4] (first letter), code_i[3:2] (second) and code_i[1:0] (third). In the three-digit build with select 00, digit 2 (leftmost) shows the first letter, digit 1 the second and digit 0 the third.
- R4: In the three-digit build, select 01 shifts the word circularly by one position and select 10 by two: the word dE1 appears as E1d and as 1dE.
- R5: In the three-digit build, select 11 gives the same digits as select 10.
- R6: In the six-digit build, select 000 places the word in digits 2, 1, 0 in letter order, and digits 5, 4, 3 show blank.
- R7: In the six-digit build, select s from 0 to 5 puts letter j (0 = first) on digit (2 + s - j) mod 6. Every digit that holds no letter shows blank. For example, s = 100 gives E, 1 on digits 5, 4 and d on digit 0.
- R8: In the six-digit build, selects 110 and 111 blank all six digits.
- R9: The outputs depend only on the present inputs. A change of code or select appears on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 6 | Three 2-bit character codes; bits [5:4] hold the first letter |
| sel_i | input | 3 (2 in the three-digit build) | Rotation position |
| seg_no | output | NUM_DIGITS x 7 | Active-low segment drive; [k][0:6] is digit k, segments a..g |

## Verification
The word dE1 is swept through every select value in both builds. This separates a correct rotation direction from a mirrored one, and a correct blank fill from a wrapped word. Arbitrary code triples, blank codes included, are then applied with random selects. These show whether each digit takes the right letter slot rather than merely the right symbol. An all-blank word and a per-code sweep on one digit pin down the glyph patterns. Changing the codes between clock edges with the select held fixed shows that the outputs do not wait for a clock.

// File: rtl/rot_disp_pkg.sv
package rot_disp_pkg;
    localparam int CODE_W      = 2;
    localparam int NUM_LETTERS = 3;
    localparam int SEG_N       = 7;

    typedef logic [CODE_W-1:0] char_code_t;

    localparam char_code_t CODE_D     = 2'b00;
    localparam char_code_t CODE_E     = 2'b01;
    localparam char_code_t CODE_ONE   = 2'b10;
    localparam char_code_t CODE_BLANK = 2'b11;
endpackage

// File: rtl/rot_mux2.sv
module rot_mux2
    import rot_disp_pkg::*;
(
    input  logic       pick_i,
    input  char_code_t a_i,
    input  char_code_t b_i,
    output char_code_t y_o
);
    always_comb begin
        for (int b = 0; b < CODE_W; b++) begin
            y_o[b] = (~pick_i & a_i[b]) | (pick_i & b_i[b]);
        end
    end
endmodule

// File: rtl/rot_mux3.sv
module rot_mux3
    import rot_disp_pkg::*;
(
    input  logic [1:0] sel_i,
    input  char_code_t u_i,
    input  char_code_t v_i,
    input  char_code_t w_i,
    output char_code_t y_o
);
    char_code_t first_q;

    rot_mux2 u_lo (.pick_i(sel_i[0]), .a_i(u_i), .b_i(v_i), .y_o(first_q));
    rot_mux2 u_hi (.pick_i(sel_i[1]), .a_i(first_q), .b_i(w_i), .y_o(y_o));

    always_comb begin
        if (sel_i == 2'b11) begin
            assert_sel3_matches_sel2_R5 : assert (y_o == w_i)
                else $error("select 11 did not pick the third input");
        end
    end
endmodule

// File: rtl/rot_mux6.sv
module rot_mux6
    import rot_disp_pkg::*;
(
    input  logic [2:0]             sel_i,
    input  logic [5:0][CODE_W-1:0] in_i,
    output char_code_t             y_o
);
    always_comb begin
        if (sel_i < 3'd6) begin
            y_o = in_i[sel_i];
        end else begin
            y_o = CODE_BLANK;
        end
    end
endmodule

// File: rtl/rot_char_decoder.sv
module rot_char_decoder
    import rot_disp_pkg::*;
(
    input  char_code_t       code_i,
    output logic [0:SEG_N-1] seg_no
);
    logic c1, c0;
    assign c1 = code_i[1];
    assign c0 = code_i[0];

    assign seg_no[0] = c1 | ~c0;
    assign seg_no[1] = c0;
    assign seg_no[2] = c0;
    assign seg_no[3] = c1;
    assign seg_no[4] = c1;
    assign seg_no[5] = c1 | ~c0;
    assign seg_no[6] = c1;

    always_comb begin
        if (code_i == CODE_BLANK) begin
            assert_blank_dark_R2 : assert (seg_no == 7'b1111111)
                else $error("blank code lit a segment");
        end else begin
            assert_letter_lit_R1 : assert ($countones(~seg_no) >= 2)
                else $error("letter code lit fewer than two segments");
        end
    end
endmodule

// File: rtl/rot_word_display.sv
module rot_word_display
    import rot_disp_pkg::*;
#(
    parameter  int NUM_DIGITS = 6,
    localparam int SEL_W      = (NUM_DIGITS == 6) ? 3 : 2
) (
    input  logic [NUM_LETTERS*CODE_W-1:0]  code_i,
    input  logic [SEL_W-1:0]               sel_i,
    output logic [NUM_DIGITS-1:0][0:SEG_N-1] seg_no
);
    logic [NUM_LETTERS-1:0][CODE_W-1:0] letter_d;
    logic [NUM_DIGITS-1:0][CODE_W-1:0]  digit_code_d;

    for (genvar j = 0; j < NUM_LETTERS; j++) begin : g_letter
        assign letter_d[j] = code_i[(NUM_LETTERS-1-j)*CODE_W +: CODE_W];
    end

    if (NUM_DIGITS == 6) begin : g_six
        logic [NUM_DIGITS-1:0][5:0][CODE_W-1:0] mux_in_d;
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
            for (genvar s = 0; s < 6; s++) begin : g_slot
                localparam int J = (2 + s - k + 6) % 6;
                if (J < NUM_LETTERS) begin : g_ltr
                    assign mux_in_d[k][s] = letter_d[J];
                end else begin : g_pad
                    assign mux_in_d[k][s] = CODE_BLANK;
                end
            end
            rot_mux6 u_mux (
                .sel_i(sel_i),
                .in_i (mux_in_d[k]),
                .y_o  (digit_code_d[k])
            );
        end

        always_comb begin
            if (sel_i >= 3'd6) begin
                assert_wide_sel_blank_R8 : assert (digit_code_d == {NUM_DIGITS{CODE_BLANK}})
                    else $error("unused select showed a letter");
            end
            if (sel_i == 3'd0) begin
                assert_home_left_blank_R6 : assert (digit_code_d[5] == CODE_BLANK)
                    else $error("home position lit the leftmost digit");
            end
        end
    end else begin : g_three
        for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
            localparam int JU = (2 - k + 3) % 3;
            localparam int JV = (3 - k + 3) % 3;
            localparam int JW = (4 - k + 3) % 3;
            rot_mux3 u_mux (
                .sel_i(sel_i),
                .u_i  (letter_d[JU]),
                .v_i  (letter_d[JV]),
                .w_i  (letter_d[JW]),
                .y_o  (digit_code_d[k])
            );
        end

        always_comb begin
            if (sel_i == 2'b00) begin
                assert_home_order_R3 : assert (digit_code_d[0] == code_i[1:0])
                    else $error("home position misplaced the third letter");
            end
        end
    end

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
        rot_char_decoder u_dec (
            .code_i(digit_code_d[k]),
            .seg_no(seg_no[k])
        );
    end
endmodule

// File: tb/tb_rot_word_display.sv
module tb_rot_word_display;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [5:0]      code;
    logic [2:0]      sel6;
    logic [1:0]      sel3;
    logic [5:0][0:6] seg6;
    logic [2:0][0:6] seg3;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    rot_word_display #(.NUM_DIGITS(6)) dut     (.code_i(code), .sel_i(sel6), .seg_no(seg6));
    rot_word_display #(.NUM_DIGITS(3)) dut_tri (.code_i(code), .sel_i(sel3), .seg_no(seg3));

    function automatic logic [0:6] glyph(input logic [1:0] c);
        case (c)
            2'b00:   return 7'b1000010;
            2'b01:   return 7'b0110000;
            2'b10:   return 7'b1001111;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic logic [1:0] letter(input logic [5:0] w, input int j);
        return w[(2-j)*2 +: 2];
    endfunction

    function automatic logic [1:0] exp3(input logic [5:0] w, input int s, input int k);
        int sp = (s == 3) ? 2 : s;
        return letter(w, (2 - k + sp) % 3);
    endfunction

    function automatic logic [1:0] exp6(input logic [5:0] w, input int s, input int k);
        int j;
        if (s > 5) return 2'b11;
        j = (2 + s - k + 6) % 6;
        if (j < 3) return letter(w, j);
        return 2'b11;
    endfunction

    task automatic chk(input string tag, input logic [0:6] act, input logic [0:6] exp, input int k);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s digit %0d code=%b sel6=%0d sel3=%0d actual=%b expected=%b",
                     tag, k, code, sel6, sel3, act, exp);
        end
    endtask

    task automatic check_all();
        string t6, t3;
        t6 = (sel6 == 0) ? "R6" : (sel6 < 6) ? "R7" : "R8";
        t3 = (sel3 == 0) ? "R3" : (sel3 == 3) ? "R5" : "R4";
        for (int k = 0; k < 6; k++) chk(t6, seg6[k], glyph(exp6(code, sel6, k)), k);
        for (int k = 0; k < 3; k++) chk(t3, seg3[k], glyph(exp3(code, sel3, k)), k);
    endtask

    task automatic apply(input logic [5:0] c, input logic [2:0] s6, input logic [1:0] s3);
        @(posedge clk);
        code = c; sel6 = s6; sel3 = s3;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        code = 6'b111111; sel6 = 3'd0; sel3 = 2'd0;
        @(negedge clk);
        // R2: all-blank word gives dark digits everywhere
        for (int k = 0; k < 6; k++) chk("R2", seg6[k], 7'b1111111, k);

        // R1: every code through digit 0 of the three-digit build at home position
        for (int c = 0; c < 4; c++) begin
            apply({4'b1111, 2'(c)}, 3'd0, 2'd0);
            chk("R1", seg3[0], glyph(2'(c)), 0);
        end

        // word dE1 through every select, both builds (R3 R4 R5 R6 R7 R8)
        for (int s = 0; s < 8; s++) apply(6'b00_01_10, 3'(s), 2'(s % 4));

        // directed spot checks named in R4 and R7
        apply(6'b00_01_10, 3'd4, 2'd1);
        chk("R7", seg6[5], glyph(2'b01), 5);
        chk("R4", seg3[2], glyph(2'b01), 2);

        // arbitrary triples
        for (int n = 0; n < 400; n++) begin
            apply(6'($urandom), 3'($urandom), 2'($urandom));
        end

        // R9: codes change between edges, outputs follow without a clock
        @(posedge clk);
        code = 6'b01_10_00; sel6 = 3'd2; sel3 = 2'd2;
        #3;
        code = 6'b10_00_01;
        #1;
        for (int k = 0; k < 6; k++) chk("R9", seg6[k], glyph(exp6(code, 2, k)), k);
        for (int k = 0; k < 3; k++) chk("R9", seg3[k], glyph(exp3(code, 2, k)), k);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule